// File: doc/BRIEF.md
# Outbound Address Window Translator

This block sits on the outbound path of a PCIe root complex. It rewrites host addresses into bus addresses. Software programs a set of windows through a 32-bit write port. Each window holds a 64-bit match value, a 64-bit mask, a 64-bit remap value and an action word.

Every valid 64-bit request address is compared against all windows in parallel, and the lowest-numbered window that hits is chosen. The block returns the rewritten address, the window's transaction type and attribute bits, the window index and a hit flag. A request marked bypass, a request that hits no window, and any request made while the global enable is clear all leave the block unchanged, with the hit flag low. The result is registered once.

Top module: `obx_top`

## Requirements
- R1: After a synchronous reset, every window is disabled, the global enable is clear, and `rsp_valid` and `rsp_hit` are low.
- R2: Each window owns a 32-byte block at byte offset `window*0x20`, with these word fields:
  - 0x00 match[31:0], where bit 0 is the window enable;
  - 0x04 match[63:32];
  - 0x08 remap[31:0];
  - 0x0C remap[63:32];
  - 0x10 mask[31:0];
  - 0x14 mask[63:32];
  - 0x18 action.
  
  The global enable is bit 0 of the word at byte offset `NUM_WIN*0x20` (0x100 by default). A window whose enable bit is clear never hits.
- R3: An enabled window hits when `(addr & mask) == (match & mask)`, with match bit 0 treated as zero in the comparison.
- R4: On a hit, `rsp_addr = (addr & ~mask) | (remap & mask)`.
- R5: When several enabled windows hit, the lowest-numbered one is used, and its index appears on `rsp_win`.
- R6: A request that hits no window returns its own address with `rsp_hit` low.
- R7: A request with `req_bypass` high returns its own address with `rsp_hit` low, even if a window hits.
- R8: While the global enable is clear, every request returns its own address with `rsp_hit` low.
- R9: `rsp_valid` is high exactly one cycle after a cycle with `req_valid` high, and the response belongs to that request.
- R10: On a hit, `rsp_type` is action[3:0] (0x0 memory, 0x4 I/O) and `rsp_attr` is action[31:20]. Without a hit, `rsp_type`, `rsp_attr` and `rsp_win` are zero.
- R11: A mask of high word 0xFFFFFFFF and low word 0xF8000000 gives a 128 MB window: the top five bits of the low word and the whole high word are compared, and the low 27 bits pass through.
- R12: A write to word offset 0x1C inside a window block changes no translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 9 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Request address valid |
| req_addr | input | 64 | Host address |
| req_bypass | input | 1 | Skip translation for this request |
| rsp_valid | output | 1 | Response valid, one cycle after request |
| rsp_addr | output | 64 | Translated or passed-through address |
| rsp_hit | output | 1 | A window translated the address |
| rsp_win | output | 3 | Index of the winning window |
| rsp_type | output | 4 | Transaction type from the action word |
| rsp_attr | output | 12 | Attribute bits from the action word |

## Verification
On every cycle, the assertions check three things:
- the one-cycle response latency;
- that a non-hit response carries the request address with zeroed type, attribute and index;
- that bypass or a clear global enable can never produce a hit, and that the chosen window is at most one and always among those that hit.

Only the directed scenarios can show the rest:
- the field layout of the register map;
- the masked compare and the remap arithmetic;
- which window wins when windows overlap;
- that the enable bit is excluded from the compare;
- that a write to the unused slot leaves translation unchanged.

// File: rtl/obx_pkg.sv
package obx_pkg;
  localparam int ADDR_W   = 64;
  localparam int REG_W    = 32;
  localparam int TYPE_W   = 4;
  localparam int ATTR_LSB = 20;
  localparam int ATTR_W   = REG_W - ATTR_LSB;

  typedef enum logic [2:0] {
    FLD_MATCH_LO = 3'd0,
    FLD_MATCH_HI = 3'd1,
    FLD_REMAP_LO = 3'd2,
    FLD_REMAP_HI = 3'd3,
    FLD_MASK_LO  = 3'd4,
    FLD_MASK_HI  = 3'd5,
    FLD_ACTION   = 3'd6,
    FLD_UNUSED   = 3'd7
  } fld_e;

  typedef struct packed {
    logic [ADDR_W-1:0] match;
    logic [ADDR_W-1:0] remap;
    logic [ADDR_W-1:0] mask;
    logic [REG_W-1:0]  action;
  } win_cfg_t;
endpackage

// File: rtl/obx_regs.sv
module obx_regs
  import obx_pkg::*;
#(
  parameter int NUM_WIN  = 8,
  parameter int WIN_BITS = $clog2(NUM_WIN),
  parameter int REG_AW   = WIN_BITS + 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [REG_AW-1:0]          wr_addr,
  input  logic [REG_W-1:0]           wr_data,
  output win_cfg_t [NUM_WIN-1:0]     cfg,
  output logic                       glb_en
);
  logic                ctrl_sel;
  logic [WIN_BITS-1:0] win_idx;
  fld_e                fld;

  assign ctrl_sel = wr_addr[REG_AW-1];
  assign win_idx  = wr_addr[5 +: WIN_BITS];
  assign fld      = fld_e'(wr_addr[4:2]);

  always_ff @(posedge clk) begin
    if (rst) glb_en <= 1'b0;
    else if (wr_en && ctrl_sel && wr_addr[REG_AW-2:0] == '0) glb_en <= wr_data[0];
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic sel;
    assign sel = wr_en && !ctrl_sel && (win_idx == WIN_BITS'(w));

    always_ff @(posedge clk) begin
      if (rst) begin
        cfg[w] <= '0;
      end else if (sel) begin
        case (fld)
          FLD_MATCH_LO: cfg[w].match[31:0]  <= wr_data;
          FLD_MATCH_HI: cfg[w].match[63:32] <= wr_data;
          FLD_REMAP_LO: cfg[w].remap[31:0]  <= wr_data;
          FLD_REMAP_HI: cfg[w].remap[63:32] <= wr_data;
          FLD_MASK_LO:  cfg[w].mask[31:0]   <= wr_data;
          FLD_MASK_HI:  cfg[w].mask[63:32]  <= wr_data;
          FLD_ACTION:   cfg[w].action       <= wr_data;
          default:      ;
        endcase
      end
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk) $past(rst) |-> !glb_en && cfg[0].match[0] == 1'b0);
endmodule

// File: rtl/obx_match.sv
module obx_match
  import obx_pkg::*;
#(
  parameter int NUM_WIN = 8
) (
  input  logic [ADDR_W-1:0]              addr,
  input  win_cfg_t [NUM_WIN-1:0]         cfg,
  output logic [NUM_WIN-1:0]             hit,
  output logic [NUM_WIN-1:0][ADDR_W-1:0] xlat
);
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    logic [ADDR_W-1:0] ref_val;
    assign ref_val = {cfg[w].match[ADDR_W-1:1], 1'b0};
    assign hit[w]  = cfg[w].match[0] && (((addr ^ ref_val) & cfg[w].mask) == '0);
    assign xlat[w] = (addr & ~cfg[w].mask) | (cfg[w].remap & cfg[w].mask);
  end
endmodule

// File: rtl/obx_select.sv
module obx_select
  import obx_pkg::*;
#(
  parameter int NUM_WIN  = 8,
  parameter int WIN_BITS = $clog2(NUM_WIN)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           req_valid,
  input  logic [ADDR_W-1:0]              req_addr,
  input  logic                           req_bypass,
  input  logic                           glb_en,
  input  logic [NUM_WIN-1:0]             hit,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0] xlat,
  input  win_cfg_t [NUM_WIN-1:0]         cfg,
  output logic                           rsp_valid,
  output logic [ADDR_W-1:0]              rsp_addr,
  output logic                           rsp_hit,
  output logic [WIN_BITS-1:0]            rsp_win,
  output logic [TYPE_W-1:0]              rsp_type,
  output logic [ATTR_W-1:0]              rsp_attr
);
  logic [WIN_BITS-1:0] pick;
  logic [NUM_WIN-1:0]  grant;
  logic                any_hit;
  logic                take;

  always_comb begin
    pick = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (hit[w]) pick = WIN_BITS'(w);
    end
    any_hit = |hit;
    grant   = any_hit ? (NUM_WIN'(1) << pick) : '0;
  end

  assign take = req_valid && glb_en && !req_bypass && any_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_hit   <= 1'b0;
      rsp_win   <= '0;
      rsp_type  <= '0;
      rsp_attr  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (take) begin
        rsp_addr <= xlat[pick];
        rsp_hit  <= 1'b1;
        rsp_win  <= pick;
        rsp_type <= cfg[pick].action[TYPE_W-1:0];
        rsp_attr <= cfg[pick].action[REG_W-1:ATTR_LSB];
      end else begin
        rsp_addr <= req_addr;
        rsp_hit  <= 1'b0;
        rsp_win  <= '0;
        rsp_type <= '0;
        rsp_attr <= '0;
      end
    end
  end

  p_grant_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant) && ((grant & ~hit) == '0));
  p_latency_r9: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  p_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  p_miss_pass_r6: assert property (@(posedge clk) disable iff (rst)
    req_valid && !take |=> rsp_addr == $past(req_addr) && !rsp_hit);
  p_bypass_r7: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_bypass |=> !rsp_hit);
  p_global_off_r8: assert property (@(posedge clk) disable iff (rst)
    req_valid && !glb_en |=> !rsp_hit);
  p_nohit_zero_r10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_hit |-> rsp_type == '0 && rsp_attr == '0 && rsp_win == '0);
endmodule

// File: rtl/obx_top.sv
module obx_top
  import obx_pkg::*;
#(
  parameter int NUM_WIN  = 8,
  parameter int WIN_BITS = $clog2(NUM_WIN),
  parameter int REG_AW   = WIN_BITS + 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [REG_AW-1:0]   cfg_addr,
  input  logic [REG_W-1:0]    cfg_wdata,
  input  logic                req_valid,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                req_bypass,
  output logic                rsp_valid,
  output logic [ADDR_W-1:0]   rsp_addr,
  output logic                rsp_hit,
  output logic [WIN_BITS-1:0] rsp_win,
  output logic [TYPE_W-1:0]   rsp_type,
  output logic [ATTR_W-1:0]   rsp_attr
);
  win_cfg_t [NUM_WIN-1:0]         cfg;
  logic                           glb_en;
  logic [NUM_WIN-1:0]             hit;
  logic [NUM_WIN-1:0][ADDR_W-1:0] xlat;

  obx_regs #(.NUM_WIN(NUM_WIN), .WIN_BITS(WIN_BITS), .REG_AW(REG_AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
    .cfg(cfg), .glb_en(glb_en)
  );

  obx_match #(.NUM_WIN(NUM_WIN)) u_match (
    .addr(req_addr), .cfg(cfg), .hit(hit), .xlat(xlat)
  );

  obx_select #(.NUM_WIN(NUM_WIN), .WIN_BITS(WIN_BITS)) u_sel (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_bypass(req_bypass), .glb_en(glb_en), .hit(hit), .xlat(xlat), .cfg(cfg),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_hit(rsp_hit), .rsp_win(rsp_win),
    .rsp_type(rsp_type), .rsp_attr(rsp_attr)
  );
endmodule

// File: tb/test_obx_top.sv
module test_obx_top;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 8;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [8:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        req_valid;
  logic [63:0] req_addr;
  logic        req_bypass;
  logic        rsp_valid;
  logic [63:0] rsp_addr;
  logic        rsp_hit;
  logic [2:0]  rsp_win;
  logic [3:0]  rsp_type;
  logic [11:0] rsp_attr;

  int checks = 0;
  int errors = 0;

  logic [63:0] m_match [NW];
  logic [63:0] m_mask  [NW];
  logic [63:0] m_remap [NW];
  logic [31:0] m_act   [NW];
  logic        m_glb;

  always #(CLK_PERIOD/2) clk = ~clk;

  obx_top i_obx_top (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_addr(req_addr), .req_bypass(req_bypass),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_hit(rsp_hit), .rsp_win(rsp_win),
    .rsp_type(rsp_type), .rsp_attr(rsp_attr)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int off, input logic [31:0] d);
    int w = off / 32;
    int f = (off % 32) / 4;
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 9'(off); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (off == NW * 32) m_glb = d[0];
    else if (w < NW) begin
      case (f)
        0: m_match[w][31:0]  = d;
        1: m_match[w][63:32] = d;
        2: m_remap[w][31:0]  = d;
        3: m_remap[w][63:32] = d;
        4: m_mask[w][31:0]   = d;
        5: m_mask[w][63:32]  = d;
        6: m_act[w]          = d;
        default: ;
      endcase
    end
  endtask

  task automatic setup_win(input int w, input logic [63:0] mt, input logic [63:0] mk,
                           input logic [63:0] rm, input logic [31:0] ac);
    wr(w*32 + 'h00, mt[31:0] & 32'hFFFF_FFFE);
    wr(w*32 + 'h04, mt[63:32]);
    wr(w*32 + 'h08, rm[31:0]);
    wr(w*32 + 'h0C, rm[63:32]);
    wr(w*32 + 'h10, mk[31:0]);
    wr(w*32 + 'h14, mk[63:32]);
    wr(w*32 + 'h18, ac);
    wr(w*32 + 'h00, mt[31:0] | 32'h1);
  endtask

  task automatic xlate(input string req, input logic [63:0] a, input logic byp);
    logic [63:0] ea = a;
    logic        eh = 1'b0;
    logic [2:0]  ew = '0;
    logic [3:0]  et = '0;
    logic [11:0] eat = '0;
    for (int w = 0; w < NW; w++) begin
      if (!eh && m_glb && !byp && m_match[w][0] &&
          ((a & m_mask[w]) == ({m_match[w][63:1], 1'b0} & m_mask[w]))) begin
        eh = 1'b1; ew = 3'(w);
        ea = (a & ~m_mask[w]) | (m_remap[w] & m_mask[w]);
        et = m_act[w][3:0]; eat = m_act[w][31:20];
      end
    end
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_bypass = byp;
    @(negedge clk);
    req_valid = 1'b0; req_bypass = 1'b0;
    check({req, " valid R9"}, 128'(rsp_valid), 128'(1));
    check({req, " addr"}, 128'(rsp_addr), 128'(ea));
    check({req, " hit"}, 128'(rsp_hit), 128'(eh));
    check({req, " win R5"}, 128'(rsp_win), 128'(ew));
    check({req, " type/attr R10"}, 128'({rsp_type, rsp_attr}), 128'({et, eat}));
  endtask

  task automatic t_reset;
    check("R1 rsp_valid after reset", 128'(rsp_valid), 128'(0));
    check("R1 rsp_hit after reset", 128'(rsp_hit), 128'(0));
    xlate("R1 no window active", 64'h0000_0012_4345_6789, 1'b0);
  endtask

  task automatic t_global_off;
    setup_win(2, 64'h0000_0012_4000_0000, 64'hFFFF_FFFF_F800_0000,
              64'h0000_0000_1000_0000, 32'h0050_0004);
    xlate("R8 global clear", 64'h0000_0012_4345_6789, 1'b0);
    wr(NW*32, 32'h1);
  endtask

  task automatic t_hit_128m;
    xlate("R11 R4 R3 128MB hit", 64'h0000_0012_4345_6789, 1'b0);
    xlate("R11 edge of window", 64'h0000_0012_47FF_FFFC, 1'b0);
    xlate("R6 just past window", 64'h0000_0012_4800_0000, 1'b0);
    xlate("R6 high word differs", 64'h0000_0013_4345_6789, 1'b0);
  endtask

  task automatic t_priority;
    setup_win(5, 64'h0000_0012_0000_0000, 64'hFFFF_FFFF_0000_0000,
              64'h0000_00A0_0000_0000, 32'h0ABC_0000);
    xlate("R5 overlap lowest wins", 64'h0000_0012_4345_6789, 1'b0);
    xlate("R5 only upper window", 64'h0000_0012_5000_0000, 1'b0);
    wr(2*32, 32'h4000_0000);
    xlate("R2 enable bit cleared", 64'h0000_0012_4345_6789, 1'b0);
    check("R2 window2 disabled routes to 5", 128'(rsp_win), 128'(5));
    wr(2*32, 32'h4000_0001);
  endtask

  task automatic t_bypass;
    xlate("R7 bypass on hitting addr", 64'h0000_0012_4345_6789, 1'b1);
    check("R7 hit low", 128'(rsp_hit), 128'(0));
  endtask

  task automatic t_unused_slot;
    wr(2*32 + 'h1C, 32'hFFFF_FFFF);
    wr(5*32 + 'h1C, 32'h1234_5678);
    xlate("R12 unused slot write", 64'h0000_0012_4345_6789, 1'b0);
    check("R12 still window 2", 128'(rsp_win), 128'(2));
  endtask

  task automatic t_idle;
    @(negedge clk);
    check("R9 no request no valid", 128'(rsp_valid), 128'(0));
  endtask

  logic done = 1'b0;
  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < NW; w++) begin
      m_match[w] = '0; m_mask[w] = '0; m_remap[w] = '0; m_act[w] = '0;
    end
    m_glb = 1'b0;
    rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_addr = '0; req_bypass = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_global_off;
    t_hit_128m;
    t_priority;
    t_bypass;
    t_unused_slot;
    t_idle;
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule